// File: doc/BRIEF.md
# Recovered-Clock Rate Monitor

This block estimates the frequency of a clock recovered from a serial link by counting its rising edges over a fixed window timed by a free-running reference clock. Each finished window gives a 16-bit rate code in unsigned 8.8 fixed point: the upper byte is whole MHz and the lower byte is 1/256 MHz steps. The code saturates at 0xFFFF. Because the window lasts 256 µs, the count of edges in one window equals the code, and the reading is refreshed well inside 1 ms.

Two status flags come from the stream of codes. The first, "absent", reports a clock below a programmable floor. The second, "steady", reports a rate that has stayed within a programmable tolerance band. A sticky change interrupt latches when the rate is lost or stops being steady, and stays set until software pulses a clear. The monitored clock needs no relation to the reference. Its edge count crosses domains as a Gray-coded value.

Top module: `clk_rate_monitor`

## Requirements
- R1: While reset is asserted, and until the first rate code is published, `freq_code` is 0, `rate_flags` is 2'b01 (absent set, steady clear) and `chg_irq` is 0.
- R2: `freq_code` equals the number of monitored rising edges in one window of WIN = REF_KHZ*256/1000 reference cycles (LSB = 1/256 MHz). It is refreshed once per window. The first window after reset only sets the baseline, so the first code appears at the end of the second window.
- R3: `rate_flags[0]` (absent) is 1 exactly when the latest code is below `lo_thr`*256.
- R4: `rate_flags[1]` (steady) drops to 0 when the latest code differs from the previous one by more than `hyst`*256. A difference within that band leaves it set.
- R5: Steady rises only after two consecutive windows that are each within the band, with absent clear.
- R6: While absent is 1, steady is 0. A window with absent set restarts the two-window count.
- R7: `chg_irq` sets when steady falls or absent rises. It then holds until a one-cycle `chg_clr` pulse clears it.
- R8: When a set event and `chg_clr` land in the same cycle, `chg_irq` is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored recovered clock, asynchronous |
| lo_thr | input | 8 | Loss floor in whole MHz |
| hyst | input | 8 | Stability band in whole MHz |
| freq_code | output | 16 | Measured rate, unsigned 8.8 MHz |
| rate_flags | output | 2 | [1] steady, [0] absent |
| chg_irq | output | 1 | Sticky change interrupt |
| chg_clr | input | 1 | Interrupt clear pulse |

## Verification
Two things can fall in the same reference cycle: the publication of a window result that raises the interrupt, and a software clear. The bench counts reference edges from the release of reset, so it knows the exact cycle in which each window result is applied. It first stops the monitored clock partway through a window and clears the interrupt that follows. It then holds `chg_clr` high on the cycle that publishes the all-zero window, which raises absent. The interrupt must read 1 right after that cycle and must fall only on a later, separate clear.

// File: rtl/clk_rate_monitor_pkg.sv
package clk_rate_monitor_pkg;
  localparam int SEQ_MAX_W  = 32;
  localparam int FLAG_ABSENT = 0;
  localparam int FLAG_STEADY = 1;

  function automatic logic [SEQ_MAX_W-1:0] bin_to_gray(input logic [SEQ_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [SEQ_MAX_W-1:0] gray_to_bin(input logic [SEQ_MAX_W-1:0] g);
    logic [SEQ_MAX_W-1:0] b;
    b[SEQ_MAX_W-1] = g[SEQ_MAX_W-1];
    for (int i = SEQ_MAX_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/crm_edge_counter.sv
module crm_edge_counter
  import clk_rate_monitor_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             mon_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] gray_cnt
);
  logic rs_a, rs_b;
  logic [CNT_W-1:0] bin_q;

  always_ff @(posedge mon_clk) begin
    rs_a <= rst;
    rs_b <= rs_a;
  end

  always_ff @(posedge mon_clk) begin
    if (rs_b) begin
      bin_q    <= '0;
      gray_cnt <= '0;
    end else begin
      bin_q    <= bin_q + 1'b1;
      gray_cnt <= CNT_W'(bin_to_gray(SEQ_MAX_W'(bin_q + 1'b1)));
    end
  end

  // R2: the crossing value moves by at most one bit per monitored edge
  p_gray_single_step_r2: assert property (@(posedge mon_clk) disable iff (rs_b)
    $countones(gray_cnt ^ $past(gray_cnt)) <= 1);
endmodule

// File: rtl/crm_window_sampler.sv
module crm_window_sampler
  import clk_rate_monitor_pkg::*;
#(
  parameter int CNT_W  = 18,
  parameter int CODE_W = 16,
  parameter int WIN    = 6400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  gray_async,
  output logic [CODE_W-1:0] code,
  output logic              code_vld
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] sync_a, sync_b, base_q, now_bin, span;
  logic             primed_q;
  logic             tick;

  assign tick    = (win_q == WIN_W'(WIN-1));
  assign now_bin = CNT_W'(gray_to_bin(SEQ_MAX_W'(sync_b)));
  assign span    = now_bin - base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      win_q  <= tick ? '0 : win_q + 1'b1;
      sync_a <= gray_async;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      primed_q <= 1'b0;
      code     <= '0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= 1'b0;
      if (tick) begin
        base_q   <= now_bin;
        primed_q <= 1'b1;
        if (primed_q) begin
          code_vld <= 1'b1;
          code     <= (|span[CNT_W-1:CODE_W]) ? '1 : span[CODE_W-1:0];
        end
      end
    end
  end

  // R2: a result is published exactly at the start of a new window
  p_refresh_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> (win_q == '0));
  // R1: no result before the baseline window has been taken
  p_no_early_result_r1: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> $past(primed_q));
endmodule

// File: rtl/crm_status_tracker.sv
module crm_status_tracker
  import clk_rate_monitor_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int FRAC_W    = 8,
  parameter int CALM_NEED = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CODE_W-1:0]        code,
  input  logic                     code_vld,
  input  logic [CODE_W-FRAC_W-1:0] lo_thr,
  input  logic [CODE_W-FRAC_W-1:0] hyst,
  input  logic                     irq_clr,
  output logic [CODE_W-1:0]        freq,
  output logic                     absent,
  output logic                     steady,
  output logic                     irq
);
  localparam int CALM_W = $clog2(CALM_NEED + 1);

  logic [CODE_W-1:0] lo_code, band_code, gap;
  logic [CALM_W-1:0] calm_q, calm_n;
  logic              low_n, wide, steady_n, set_ev;

  assign lo_code   = {lo_thr, {FRAC_W{1'b0}}};
  assign band_code = {hyst, {FRAC_W{1'b0}}};
  assign low_n     = code < lo_code;
  assign gap       = (code >= freq) ? code - freq : freq - code;
  assign wide      = gap > band_code;

  always_comb begin
    calm_n   = calm_q;
    steady_n = steady;
    if (code_vld) begin
      if (low_n || wide)                   calm_n = '0;
      else if (calm_q != CALM_W'(CALM_NEED)) calm_n = calm_q + 1'b1;
      steady_n = (calm_n == CALM_W'(CALM_NEED));
    end
  end

  assign set_ev = code_vld && ((steady && !steady_n) || (!absent && low_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      freq   <= '0;
      absent <= 1'b1;
      steady <= 1'b0;
      calm_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (code_vld) begin
        freq   <= code;
        absent <= low_n;
      end
      steady <= steady_n;
      calm_q <= calm_n;
      irq    <= set_ev | (irq & ~irq_clr);
    end
  end

  // R6: a missing clock never reads as steady
  p_absent_blocks_steady_r6: assert property (@(posedge clk) disable iff (rst)
    absent |-> !steady);
  // R5: steady only comes up with the clock present
  p_steady_needs_clock_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(steady) |-> !absent);
  // R7: loss of clock is always flagged
  p_loss_raises_irq_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(absent) |-> irq);
  // R7: loss of stability is always flagged
  p_unsteady_raises_irq_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(steady) |-> irq);
  // R7: the interrupt holds without a clear
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  // R2: the reported rate only moves on a published window
  p_rate_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !code_vld |=> $stable(freq));
endmodule

// File: rtl/clk_rate_monitor.sv
module clk_rate_monitor
  import clk_rate_monitor_pkg::*;
#(
  parameter int REF_KHZ   = 25000,
  parameter int CNT_W     = 18,
  parameter int CODE_W    = 16,
  parameter int FRAC_W    = 8,
  parameter int CALM_NEED = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mon_clk,
  input  logic [CODE_W-FRAC_W-1:0] lo_thr,
  input  logic [CODE_W-FRAC_W-1:0] hyst,
  output logic [CODE_W-1:0]        freq_code,
  output logic [1:0]               rate_flags,
  output logic                     chg_irq,
  input  logic                     chg_clr
);
  localparam int WIN = REF_KHZ * (2 ** FRAC_W) / 1000;

  logic [CNT_W-1:0]  gray_cnt;
  logic [CODE_W-1:0] code;
  logic              code_vld, absent, steady;

  crm_edge_counter #(.CNT_W(CNT_W)) u_edges (
    .mon_clk (mon_clk),
    .rst     (rst),
    .gray_cnt(gray_cnt)
  );

  crm_window_sampler #(.CNT_W(CNT_W), .CODE_W(CODE_W), .WIN(WIN)) u_window (
    .clk       (clk),
    .rst       (rst),
    .gray_async(gray_cnt),
    .code      (code),
    .code_vld  (code_vld)
  );

  crm_status_tracker #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .CALM_NEED(CALM_NEED)) u_status (
    .clk     (clk),
    .rst     (rst),
    .code    (code),
    .code_vld(code_vld),
    .lo_thr  (lo_thr),
    .hyst    (hyst),
    .irq_clr (chg_clr),
    .freq    (freq_code),
    .absent  (absent),
    .steady  (steady),
    .irq     (chg_irq)
  );

  assign rate_flags[FLAG_ABSENT] = absent;
  assign rate_flags[FLAG_STEADY] = steady;
endmodule

// File: tb/test_clk_rate_monitor.sv
`timescale 1ns/1ps
module test_clk_rate_monitor;
  localparam int REF_KHZ = 8000;
  localparam int WIN     = REF_KHZ * 256 / 1000;

  logic        clk = 1'b0, rst = 1'b1, mon_clk = 1'b0, chg_clr = 1'b0;
  logic [7:0]  lo_thr = 8'd4, hyst = 8'd1;
  logic [15:0] freq_code;
  logic [1:0]  rate_flags;
  logic        chg_irq;
  int          checks = 0, failures = 0, ecnt = 0;
  bit          mon_run = 1'b1;
  realtime     mon_half = 1.0;

  clk_rate_monitor #(.REF_KHZ(REF_KHZ)) i_clk_rate_monitor (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .lo_thr(lo_thr), .hyst(hyst),
    .freq_code(freq_code), .rate_flags(rate_flags), .chg_irq(chg_irq), .chg_clr(chg_clr)
  );

  always #2 clk = ~clk;
  always begin
    if (mon_run) #(mon_half) mon_clk = ~mon_clk;
    else begin mon_clk = 1'b0; #1; end
  end
  always @(posedge clk) ecnt <= rst ? 0 : ecnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d+-%0d", req, act, exp, tol);
    end
  endtask

  // samples after the update that follows the k-th window close
  task automatic at_report(input int k);
    while (ecnt != k*WIN + 2) @(negedge clk);
  endtask

  task automatic pulse_clr;
    chg_clr = 1'b1; @(negedge clk); chg_clr = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 code after reset", freq_code, 0);
    chk("R1 flags after reset", rate_flags, 2'b01);
    chk("R1 irq after reset", chg_irq, 0);
    while (ecnt != WIN + 10) @(negedge clk);
    chk("R1 code during baseline window", freq_code, 0);
    chk("R1 flags during baseline window", rate_flags, 2'b01);
  endtask

  task automatic t_lock;
    at_report(2);
    chk_near("R2 code at 500 edges/us", freq_code, 4096, 8);
    chk("R3 absent clear above floor", rate_flags[0], 0);
    chk("R5 not steady after first code", rate_flags[1], 0);
    at_report(3);
    chk("R5 not steady after one calm window", rate_flags[1], 0);
    at_report(4);
    chk("R5 steady after two calm windows", rate_flags[1], 1);
    chk("R7 no irq while locking", chg_irq, 0);
  endtask

  task automatic t_step;
    mon_half = 2.0;
    at_report(5);
    chk_near("R2 code after halving rate", freq_code, 2048, 8);
    chk("R4 steady drops on large step", rate_flags[1], 0);
    chk("R7 irq set on steady fall", chg_irq, 1);
    at_report(6);
    chk("R7 irq sticky across window", chg_irq, 1);
    pulse_clr;
    chk("R7 irq cleared by pulse", chg_irq, 0);
    at_report(7);
    chk("R5 steady regained", rate_flags[1], 1);
    mon_half = 2.1;
    at_report(8);
    chk_near("R2 code at 4.2 ns period", freq_code, 1950, 8);
    chk("R4 small step keeps steady", rate_flags[1], 1);
    chk("R4 small step raises no irq", chg_irq, 0);
  endtask

  task automatic t_floor;
    lo_thr = 8'd9;
    at_report(9);
    chk("R3 absent set below floor", rate_flags[0], 1);
    chk("R6 steady forced low", rate_flags[1], 0);
    chk("R7 irq set on absent rise", chg_irq, 1);
    pulse_clr;
    lo_thr = 8'd4;
    at_report(10);
    chk("R3 absent clear after floor lowered", rate_flags[0], 0);
    chk("R6 count restarted after absent", rate_flags[1], 0);
    chk("R7 absent fall raises no irq", chg_irq, 0);
    at_report(11);
    chk("R5 steady after recovery", rate_flags[1], 1);
  endtask

  task automatic t_collide;
    while (ecnt != 11*WIN + 1536) @(negedge clk);
    mon_run = 1'b0;
    at_report(12);
    chk("R7 irq on partial window", chg_irq, 1);
    pulse_clr;
    chk("R7 irq cleared before collision", chg_irq, 0);
    while (ecnt != 13*WIN) @(negedge clk);
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
    chk("R8 set wins over same-cycle clear", chg_irq, 1);
    chk("R3 absent with stopped clock", rate_flags[0], 1);
    chk("R2 zero code with stopped clock", freq_code, 0);
    pulse_clr;
    chk("R7 later clear takes effect", chg_irq, 0);
  endtask

  initial begin
    t_reset;
    t_lock;
    t_step;
    t_floor;
    t_collide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule